// File: doc/BRIEF.md
# Code-Protect Configuration Guard

This block keeps a 16-bit configuration word and uses two of its bits to guard a small code memory model. One bit turns on write protection and the other turns on read protection. Both are active low, so a cleared bit means the protection is on. The word is changed one byte per request. A byte program can only move bits from 1 to 0, and a bit that has been cleared can only return to 1 through a bulk erase. Bits that the word does not implement always read as 1.

Code memory reads and program requests pass through the guard. When read protection is on, a read returns zero no matter what the memory holds. When write protection is on, a program request leaves the memory unchanged and reports failure. A program request also fails while read protection is on, because its verify readback returns zero. Every program request ends with a one-cycle done pulse and a pass flag.

The stored word and the memory contents are not cleared by reset. Only program and erase requests change them, so they behave like nonvolatile storage.

Top module: `code_protect_guard`

## Requirements
- R1: `wr_prot_o` is 1 exactly when bit 12 of `cfg_word_o` is 0. `rd_prot_o` is 1 exactly when bit 13 of `cfg_word_o` is 0.
- R2: One cycle after `erase_i` is sampled, `cfg_word_o` is 16'hFFFF and every code memory word is all ones.
- R3: A code program request sampled while write protection is on leaves the memory unchanged and ends with `pg_pass_o` = 0.
- R4: A read sampled while read protection is on returns 0 on `rd_data_o`, whatever the stored contents.
- R5: A code program request sampled while read protection is on ends with `pg_pass_o` = 0, even when the written data is 0.
- R6: `cfg_hi_i` = 1 selects bits 15:8 and `cfg_hi_i` = 0 selects bits 7:0. A configuration byte program sets the selected byte to the old byte ANDed with `cfg_byte_i`, so no bit can return from 0 to 1 except through an erase.
- R7: Bits 15:14 and 11:8 are reserved and always hold 1 after any program or erase, even when a 0 is written to them.
- R8: Each program request gives a one-cycle done pulse on the cycle after it is sampled. The pass flag is 1 only when the verify readback equals the written data: the selected byte with reserved bits forced to 1 for a configuration program, or the stored word for a code program. Both done outputs are 0 during reset.
- R9: Asserting `rst_ni` changes neither the configuration word nor the code memory.
- R10: When an erase and a program request are sampled in the same cycle, the erase takes effect. The program request has no effect, and its done pulse carries pass = 0.
- R11: `rd_data_o` updates on the clock edge that samples `rd_en_i` = 1 and holds its value while `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_i | input | 1 | Bulk erase request |
| cfg_prog_i | input | 1 | Configuration byte program request |
| cfg_hi_i | input | 1 | Byte select: 1 for bits 15:8, 0 for bits 7:0 |
| cfg_byte_i | input | 8 | Configuration byte to program |
| cfg_done_o | output | 1 | Configuration program done pulse |
| cfg_pass_o | output | 1 | Configuration program pass flag |
| cfg_word_o | output | 16 | Current configuration word |
| wr_prot_o | output | 1 | Write protection is on |
| rd_prot_o | output | 1 | Read protection is on |
| rd_en_i | input | 1 | Code memory read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, masked to 0 under read protection |
| pg_en_i | input | 1 | Code memory program request |
| pg_addr_i | input | ADDR_W | Program address |
| pg_data_i | input | DATA_W | Program data |
| pg_done_o | output | 1 | Code program done pulse |
| pg_pass_o | output | 1 | Code program pass flag |

## Verification
All requests are sampled on one rising edge. The configuration word, the protection flags, the erased memory and `rd_data_o` all change on that same edge. The done and pass outputs of both program paths are valid in the cycle that follows that edge. The bench drives each request at a falling edge and lets one rising edge pass. It removes the request and samples the outputs at the next falling edge, which is exactly where every result is due. To check results that are not outputs, the bench makes follow-up reads through the normal read port: memory left unchanged under write protection, contents that survive reset, and words filled by an erase.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WP_BIT   = 12;
  localparam int unsigned RP_BIT   = 13;
  // implemented bits: protection pair plus low byte; the rest reserved (read as 1)
  localparam logic [CFG_W-1:0] CFG_IMPL   = 16'h30FF;
  localparam logic [CFG_W-1:0] CFG_ERASED = '1;

  typedef struct packed {
    logic rd;
    logic wr;
  } prot_t;
endpackage

// File: rtl/cpg_cfg_store.sv
module cpg_cfg_store
  import cpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              prog_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              done_o,
  output logic              pass_o
);
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [BYTE_W-1:0] res_byte, old_byte, new_byte, want_byte;
  logic              done_q, pass_q;

  always_comb begin
    res_byte  = hi_i ? ~CFG_IMPL[CFG_W-1:BYTE_W] : ~CFG_IMPL[BYTE_W-1:0];
    old_byte  = hi_i ? cfg_q[CFG_W-1:BYTE_W] : cfg_q[BYTE_W-1:0];
    new_byte  = (old_byte & byte_i) | res_byte;
    want_byte = byte_i | res_byte;
    cfg_d     = cfg_q;
    if (erase_i) begin
      cfg_d = CFG_ERASED;
    end else if (prog_i) begin
      if (hi_i) cfg_d[CFG_W-1:BYTE_W] = new_byte;
      else      cfg_d[BYTE_W-1:0]     = new_byte;
    end
  end

  // storage is nonvolatile-style: untouched by reset
  always_ff @(posedge clk_i) cfg_q <= cfg_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= prog_i;
      pass_q <= prog_i & ~erase_i & (new_byte == want_byte);
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;
  assign pass_o = pass_q;

  assert_erase_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (cfg_q == CFG_ERASED));
  assert_no_unset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> ((cfg_q & ~$past(cfg_q) & CFG_IMPL) == '0));
  assert_reserved_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i || erase_i) |=> ((cfg_q | CFG_IMPL) == CFG_ERASED));
endmodule

// File: rtl/cpg_code_array.sv
module cpg_code_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (erase_i) begin
        mem_q[i] <= '1;
      end else if (we_i && (waddr_i == ADDR_W'(i))) begin
        mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !erase_i) |=> (mem_q == $past(mem_q)));
  assert_erase_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (&mem_q));
endmodule

// File: rtl/cpg_read_gate.sv
module cpg_read_gate #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_prot_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_en_i) data_q <= rd_prot_i ? '0 : word_i;
  end

  assign rd_data_o = data_q;

  assert_rd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_prot_i) |=> (rd_data_o == '0));
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/cpg_prog_verify.sv
module cpg_prog_verify
  import cpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  prot_t             prot_i,
  input  logic              pg_en_i,
  input  logic [ADDR_W-1:0] pg_addr_i,
  input  logic [DATA_W-1:0] pg_data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] vfy_addr_o,
  input  logic [DATA_W-1:0] vfy_word_i,
  output logic              done_o,
  output logic              pass_o
);
  logic              pend_q, ok_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] readback;

  assign we_o = pg_en_i & ~prot_i.wr & ~erase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ok_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pg_en_i;
      ok_q   <= we_o & ~prot_i.rd;
      if (pg_en_i) begin
        addr_q <= pg_addr_i;
        data_q <= pg_data_i;
      end
    end
  end

  // verify reads through the same protection mask as the read port
  assign readback   = prot_i.rd ? '0 : vfy_word_i;
  assign vfy_addr_o = addr_q;
  assign done_o     = pend_q;
  assign pass_o     = pend_q & ok_q & (readback == data_q);

  assert_prot_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_en_i && (prot_i.wr || prot_i.rd)) |=> (done_o && !pass_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pg_en_i));
  assert_erase_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_en_i && erase_i) |=> !pass_o);
endmodule

// File: rtl/code_protect_guard.sv
module code_protect_guard
  import cpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              cfg_prog_i,
  input  logic              cfg_hi_i,
  input  logic [7:0]        cfg_byte_i,
  output logic              cfg_done_o,
  output logic              cfg_pass_o,
  output logic [15:0]       cfg_word_o,
  output logic              wr_prot_o,
  output logic              rd_prot_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pg_en_i,
  input  logic [ADDR_W-1:0] pg_addr_i,
  input  logic [DATA_W-1:0] pg_data_i,
  output logic              pg_done_o,
  output logic              pg_pass_o
);
  logic [CFG_W-1:0]  cfg;
  prot_t             prot;
  logic              mem_we;
  logic [ADDR_W-1:0] vfy_addr;
  logic [DATA_W-1:0] rd_word, vfy_word;

  cpg_cfg_store u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_i),
    .prog_i  (cfg_prog_i),
    .hi_i    (cfg_hi_i),
    .byte_i  (cfg_byte_i),
    .cfg_o   (cfg),
    .done_o  (cfg_done_o),
    .pass_o  (cfg_pass_o)
  );

  // active-low protection bits
  assign prot.wr = ~cfg[WP_BIT];
  assign prot.rd = ~cfg[RP_BIT];

  cpg_code_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .erase_i   (erase_i),
    .we_i      (mem_we),
    .waddr_i   (pg_addr_i),
    .wdata_i   (pg_data_i),
    .raddr_a_i (rd_addr_i),
    .raddr_b_i (vfy_addr),
    .rdata_a_o (rd_word),
    .rdata_b_o (vfy_word)
  );

  cpg_read_gate #(.DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_prot_i (prot.rd),
    .word_i    (rd_word),
    .rd_data_o (rd_data_o)
  );

  cpg_prog_verify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_i    (erase_i),
    .prot_i     (prot),
    .pg_en_i    (pg_en_i),
    .pg_addr_i  (pg_addr_i),
    .pg_data_i  (pg_data_i),
    .we_o       (mem_we),
    .vfy_addr_o (vfy_addr),
    .vfy_word_i (vfy_word),
    .done_o     (pg_done_o),
    .pass_o     (pg_pass_o)
  );

  assign cfg_word_o = cfg;
  assign wr_prot_o  = prot.wr;
  assign rd_prot_o  = prot.rd;

  assert_prot_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prot_o == !cfg_word_o[WP_BIT]) && (rd_prot_o == !cfg_word_o[RP_BIT]));
endmodule

// File: tb/code_protect_guard_tb_top.sv
module code_protect_guard_tb_top;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          erase_i = 1'b0;
  logic          cfg_prog_i = 1'b0;
  logic          cfg_hi_i = 1'b0;
  logic [7:0]    cfg_byte_i = '0;
  logic          cfg_done_o, cfg_pass_o;
  logic [15:0]   cfg_word_o;
  logic          wr_prot_o, rd_prot_o;
  logic          rd_en_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          pg_en_i = 1'b0;
  logic [AW-1:0] pg_addr_i = '0;
  logic [DW-1:0] pg_data_i = '0;
  logic          pg_done_o, pg_pass_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  code_protect_guard #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .erase_i(erase_i),
    .cfg_prog_i(cfg_prog_i), .cfg_hi_i(cfg_hi_i), .cfg_byte_i(cfg_byte_i),
    .cfg_done_o(cfg_done_o), .cfg_pass_o(cfg_pass_o), .cfg_word_o(cfg_word_o),
    .wr_prot_o(wr_prot_o), .rd_prot_o(rd_prot_o),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pg_en_i(pg_en_i), .pg_addr_i(pg_addr_i), .pg_data_i(pg_data_i),
    .pg_done_o(pg_done_o), .pg_pass_o(pg_pass_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_erase();
    erase_i = 1'b1;
    tick();
    erase_i = 1'b0;
  endtask

  task automatic cfg_prog(input logic hi, input logic [7:0] b, input logic [15:0] exp_word,
                          input logic exp_pass, input string req);
    cfg_prog_i = 1'b1; cfg_hi_i = hi; cfg_byte_i = b;
    tick();
    cfg_prog_i = 1'b0;
    check({req, " cfg done"}, cfg_done_o, 1);
    check({req, " cfg pass"}, cfg_pass_o, exp_pass);
    check({req, " cfg word"}, cfg_word_o, exp_word);
    check("R1 prot flags", {wr_prot_o, rd_prot_o}, {!exp_word[12], !exp_word[13]});
  endtask

  task automatic code_prog(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic exp_pass, input string req);
    pg_en_i = 1'b1; pg_addr_i = a; pg_data_i = d;
    tick();
    pg_en_i = 1'b0;
    check({req, " pg done"}, pg_done_o, 1);
    check({req, " pg pass"}, pg_pass_o, exp_pass);
    tick();
    check("R8 done is one cycle", pg_done_o, 0);
  endtask

  task automatic code_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    rd_en_i = 1'b1; rd_addr_i = a;
    tick();
    rd_en_i = 1'b0;
    check({req, " read data"}, rd_data_o, exp);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R8 reset pg_done", pg_done_o, 0);
    check("R8 reset cfg_done", cfg_done_o, 0);
    check("R11 reset rd_data", rd_data_o, 0);
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_erase_opens();
    do_erase();
    check("R2 erase cfg word", cfg_word_o, 16'hFFFF);
    check("R1 unprotected", {wr_prot_o, rd_prot_o}, 2'b00);
  endtask

  task automatic t_program_and_read();
    code_prog(3, 16'hA5A5, 1, "R8 normal program");
    code_read(3, 16'hA5A5, "R11 readback");
    tick();
    check("R11 hold while idle", rd_data_o, 16'hA5A5);
    code_prog(7, 16'h0000, 1, "R8 zero data passes unprotected");
    code_read(7, 16'h0000, "R11 zero readback");
  endtask

  task automatic t_cfg_and_only();
    cfg_prog(0, 8'h12, 16'hFF12, 1, "R6 low byte");
    cfg_prog(0, 8'hFF, 16'hFF12, 0, "R6 cannot set back");
  endtask

  task automatic t_write_protect();
    cfg_prog(1, 8'hEF, 16'hEF12, 1, "R1 write protect on");
    code_prog(3, 16'h1111, 0, "R3 program blocked");
    code_read(3, 16'hA5A5, "R3 memory unchanged");
    cfg_prog(1, 8'hFF, 16'hEF12, 0, "R6 wp stays cleared");
  endtask

  task automatic t_read_protect();
    cfg_prog(1, 8'hDF, 16'hCF12, 0, "R6 rp cleared, wp bit mismatch");
    code_read(3, 16'h0000, "R4 masked read");
    code_prog(7, 16'h0000, 0, "R5 program fails under rp");
  endtask

  task automatic t_reset_keeps();
    rst_ni = 1'b0;
    tick();
    check("R9 cfg kept in reset", cfg_word_o, 16'hCF12);
    rst_ni = 1'b1;
    tick();
    check("R9 cfg kept after reset", cfg_word_o, 16'hCF12);
    do_erase();
    code_read(3, 16'hFFFF, "R2 erased memory word");
    code_prog(9, 16'h5A5A, 1, "R8 program before reset");
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
    code_read(9, 16'h5A5A, "R9 memory kept over reset");
  endtask

  task automatic t_reserved();
    cfg_prog(1, 8'h00, 16'hCFFF, 1, "R7 reserved forced high");
    cfg_prog(0, 8'h00, 16'hCF00, 1, "R7 low byte implemented");
    do_erase();
    check("R2 erase restores", cfg_word_o, 16'hFFFF);
  endtask

  task automatic t_erase_priority();
    erase_i = 1'b1; pg_en_i = 1'b1; pg_addr_i = 4; pg_data_i = 16'h0F0F;
    cfg_prog_i = 1'b1; cfg_hi_i = 1'b0; cfg_byte_i = 8'h00;
    tick();
    erase_i = 1'b0; pg_en_i = 1'b0; cfg_prog_i = 1'b0;
    check("R10 pg done", pg_done_o, 1);
    check("R10 pg fails", pg_pass_o, 0);
    check("R10 cfg fails", cfg_pass_o, 0);
    check("R10 cfg erased", cfg_word_o, 16'hFFFF);
    code_read(4, 16'hFFFF, "R10 memory erased");
  endtask

  task automatic t_rp_only();
    cfg_prog(1, 8'hDF, 16'hDFFF, 1, "R1 read protect only");
    code_prog(2, 16'h1234, 0, "R5 rp only fails");
    do_erase();
  endtask

  initial begin
    t_reset_state();
    t_erase_opens();
    t_program_and_read();
    t_cfg_and_only();
    t_write_protect();
    t_read_protect();
    t_reset_keeps();
    t_reserved();
    t_erase_priority();
    t_rp_only();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule